// File: doc/BRIEF.md
# Store Buffer with Selectable Drain Order and Fences

This block is a per-core store buffer. It takes one request at a time from an in-order load/store stream and sits in front of a single-ported memory. Stores are retired into a small buffer at once and written to memory in the background. Loads do not wait for buffered stores. A load takes its value from the youngest buffered store to its address when one exists. Otherwise it reads memory, and it may get there before older buffered stores to other addresses.

The `relaxed` input selects the drain policy. When it is low, stores reach memory strictly in program order. When it is high, stores to different addresses may reach memory out of order. The policy then starts the youngest store that is free to go, but stores to the same address still leave in program order. Four fence codes limit the reorderings:

- store-to-load fence: held until the buffer is empty and no load is outstanding.
- store-to-store fence: never stalls the request stream. It stops every younger store from draining until all older stores have drained.
- load-to-load fence and load-to-store fence: each is held while a load is still outstanding.

Top module: `store_order_buffer`

## Requirements
- R1: After reset `idle` is 1, `mem_req` and `rsp_valid` are 0, and a request is accepted at once.
- R2: Every load returns the data of the youngest store to its address accepted before it, or the memory content when no such store exists. Request codes: 0 load, 1 store, 2 load-to-load fence, 3 load-to-store fence, 4 store-to-load fence, 5 store-to-store fence.
- R3: A load whose address matches a buffered store makes no memory read, and `rsp_valid` is high in the cycle after the load's accept edge.
- R4: A load with no matching buffered store reads memory. It may do so before older buffered stores that have not started draining. Its `rsp_valid` is high in the cycle after the read's `mem_req && mem_ack` edge.
- R5: With `relaxed` low, memory writes occur in the order the stores were accepted.
- R6: With `relaxed` high, the next write is the youngest buffered store that has no older buffered store to the same address and is not held by a fence. Writes to one address keep program order.
- R7: With DEPTH stores buffered (the one being written counts until its acknowledge), `req_ready` is low for a store.
- R8: A store-to-load fence is accepted only when `idle` is 1. At that point every earlier store has been written.
- R9: No store accepted after a store-to-store fence is written while a store accepted before that fence is still unwritten.
- R10: Load-to-load and load-to-store fences are not accepted while a load is outstanding.
- R11: `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`.
- R12: `idle` is 1 exactly when the buffer is empty and no load is outstanding. While `idle` is 1, `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| relaxed | input | 1 | 0: in-order drain, 1: out-of-order drain |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request code, see R2 |
| req_addr | input | AW | Load or store address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted on this edge when `req_valid` is high |
| rsp_valid | output | 1 | Load data valid, one cycle |
| rsp_data | output | DW | Load data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the access on this edge |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| idle | output | 1 | Buffer empty and no load outstanding |

## Verification
A forwarded load answers in the cycle after its accept edge. The bench samples `rsp_valid` at the first falling edge after that accept. A memory load answers in the cycle after the read acknowledge. The bench memory model arms a one-shot check when it grants a read and tests `rsp_valid` at the next falling edge. Memory writes are judged when the model grants them, against a program-order record of accepted stores. Fence effects are checked at the first falling edge after the fence is accepted.

// File: rtl/sbuf_pkg.sv
// Shared request encoding for the store buffer.
// Assumes a 3-bit request code; codes 6 and 7 are unused.
package sbuf_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_F_RR  = 3'd2,
        OP_F_RW  = 3'd3,
        OP_F_WR  = 3'd4,
        OP_F_WW  = 3'd5
    } sb_op_e;
endpackage

// File: rtl/sb_slots.sv
// Compacting store slot array: slot 0 is the oldest entry.
// Appends at the tail and removes any slot, shifting younger ones down.
// Gives youngest-match forwarding and picks the next slot to drain.
// Assumes the caller pushes only when not full and pops only a valid slot.
module sb_slots #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          relaxed,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          push_bar,
    input  logic          pop,
    input  logic [IW-1:0] pop_idx,
    input  logic [AW-1:0] look_addr,
    output logic [CW-1:0] cnt,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic          dr_ok,
    output logic [IW-1:0] dr_idx,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data
);
    logic [DEPTH-1:0] v_q, v_n, bar_q, bar_n, elig;
    logic [AW-1:0]    a_q [DEPTH];
    logic [AW-1:0]    a_n [DEPTH];
    logic [DW-1:0]    d_q [DEPTH];
    logic [DW-1:0]    d_n [DEPTH];
    logic [CW-1:0]    cnt_q, tail;
    logic             blk;

    function automatic int up1(input int i);
        return (i < DEPTH - 1) ? i + 1 : i;
    endfunction

    // Next slot contents: remove the popped slot, then append the pushed store.
    always_comb begin
        v_n = v_q; bar_n = bar_q; a_n = a_q; d_n = d_q;
        if (pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= int'(pop_idx)) begin
                    v_n[i]   = v_q[up1(i)];
                    bar_n[i] = bar_q[up1(i)];
                    a_n[i]   = a_q[up1(i)];
                    d_n[i]   = d_q[up1(i)];
                    if (i == DEPTH - 1) begin
                        v_n[i]   = 1'b0;
                        bar_n[i] = 1'b0;
                    end
                end
            end
        end
        tail = cnt_q - CW'(pop);
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(tail)) begin
                    v_n[i]   = 1'b1;
                    bar_n[i] = push_bar;
                    a_n[i]   = push_addr;
                    d_n[i]   = push_data;
                end
            end
        end
    end

    // Valid, barrier and occupancy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= '0;
            bar_q <= '0;
            cnt_q <= '0;
        end else begin
            v_q   <= v_n;
            bar_q <= bar_n;
            cnt_q <= cnt_q - CW'(pop) + CW'(push);
        end
    end

    // Address and data payload, no reset needed.
    always_ff @(posedge clk) begin
        a_q <= a_n;
        d_q <= d_n;
    end

    // Forwarding lookup: the last match in age order is the youngest.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (v_q[i] && a_q[i] == look_addr) begin
                hit      = 1'b1;
                hit_data = d_q[i];
            end
        end
    end

    // Drain choice: oldest slot when ordered, youngest free slot when relaxed.
    always_comb begin
        elig = '0;
        blk  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            blk = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (v_q[j] && a_q[j] == a_q[i]) blk = 1'b1;
            end
            for (int j = 1; j <= i; j++) begin
                if (v_q[j] && bar_q[j]) blk = 1'b1;
            end
            elig[i] = v_q[i] && !blk;
        end
        dr_ok  = 1'b0;
        dr_idx = '0;
        if (!relaxed) begin
            dr_ok = v_q[0];
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (elig[i]) begin
                    dr_ok  = 1'b1;
                    dr_idx = IW'(i);
                end
            end
        end
    end

    assign cnt     = cnt_q;
    assign dr_addr = a_q[dr_idx];
    assign dr_data = d_q[dr_idx];
endmodule

// File: rtl/sb_port.sv
// Single memory port sequencer: one access in flight, loads win arbitration.
// Latches the address and data at start and holds them until acknowledge.
// Assumes slot indices of the buffer stay fixed while a drain is in flight.
module sb_port #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_want,
    input  logic [AW-1:0] ld_addr,
    input  logic          dr_ok,
    input  logic [IW-1:0] dr_idx,
    input  logic [AW-1:0] dr_addr,
    input  logic [DW-1:0] dr_data,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          ld_done,
    output logic          pop,
    output logic [IW-1:0] pop_idx
);
    logic          busy_q, is_ld_q;
    logic [IW-1:0] slot_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    // Start a load or a drain when free, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            is_ld_q <= 1'b0;
            slot_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (!busy_q) begin
            if (ld_want) begin
                busy_q  <= 1'b1;
                is_ld_q <= 1'b1;
                addr_q  <= ld_addr;
            end else if (dr_ok) begin
                busy_q  <= 1'b1;
                is_ld_q <= 1'b0;
                slot_q  <= dr_idx;
                addr_q  <= dr_addr;
                wdata_q <= dr_data;
            end
        end else if (mem_ack) begin
            busy_q <= 1'b0;
        end
    end

    assign mem_req   = busy_q;
    assign mem_we    = busy_q && !is_ld_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign ld_done   = busy_q && is_ld_q && mem_ack;
    assign pop       = busy_q && !is_ld_q && mem_ack;
    assign pop_idx   = slot_q;
endmodule

// File: rtl/store_order_buffer.sv
// Store buffer top: accepts one request per cycle and forwards loads from
// buffered stores. Misses go to memory. Stores drain in the background
// under the ordered or relaxed policy. Fences are applied at request
// accept, or as a barrier mark on the next stored entry.
// Assumes the memory keeps mem_rdata valid in the acknowledge cycle.
module store_order_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          relaxed,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          idle
);
    logic [CW-1:0] cnt;
    logic          hit, dr_ok, ld_done, pop, push, accept;
    logic [DW-1:0] hit_data, dr_data;
    logic [IW-1:0] dr_idx, pop_idx;
    logic [AW-1:0] dr_addr, ld_addr_q;
    logic          ld_pend_q, bar_pend_q, empty, full;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign accept = req_valid && req_ready;
    assign push   = accept && req_op == OP_STORE;
    assign idle   = empty && !ld_pend_q;

    // Acceptance rules per request code.
    always_comb begin
        case (req_op)
            OP_LOAD:          req_ready = !ld_pend_q;
            OP_STORE:         req_ready = !full;
            OP_F_RR, OP_F_RW: req_ready = !ld_pend_q;
            OP_F_WR:          req_ready = idle;
            default:          req_ready = 1'b1;
        endcase
    end

    // Load tracking, response register and store-to-store barrier mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q  <= 1'b0;
            ld_addr_q  <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            bar_pend_q <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && req_op == OP_LOAD) begin
                if (hit) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= hit_data;
                end else begin
                    ld_pend_q <= 1'b1;
                    ld_addr_q <= req_addr;
                end
            end
            if (ld_done) begin
                ld_pend_q <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_data  <= mem_rdata;
            end
            if (accept && req_op == OP_F_WW && !empty) bar_pend_q <= 1'b1;
            else if (push) bar_pend_q <= 1'b0;
        end
    end

    sb_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .relaxed   (relaxed),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .push_bar  (bar_pend_q),
        .pop       (pop),
        .pop_idx   (pop_idx),
        .look_addr (req_addr),
        .cnt       (cnt),
        .hit       (hit),
        .hit_data  (hit_data),
        .dr_ok     (dr_ok),
        .dr_idx    (dr_idx),
        .dr_addr   (dr_addr),
        .dr_data   (dr_data)
    );

    sb_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_want   (ld_pend_q),
        .ld_addr   (ld_addr_q),
        .dr_ok     (dr_ok),
        .dr_idx    (dr_idx),
        .dr_addr   (dr_addr),
        .dr_data   (dr_data),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ld_done   (ld_done),
        .pop       (pop),
        .pop_idx   (pop_idx)
    );
endmodule

// File: rtl/sob_chk.sv
// Protocol checker for the store buffer, bound to every instance.
// Observes ports only.
module sob_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [2:0]    req_op,
    input logic          rsp_valid,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          idle
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R8
    fence_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_op == 3'd4 |-> idle && !mem_req);

    // R10
    fence_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_op == 3'd2 || req_op == 3'd3) |-> !(mem_req && !mem_we));

    // R4
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready && req_op == 3'd0) || (mem_req && mem_ack && !mem_we)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req);
endmodule

bind store_order_buffer sob_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .idle      (idle)
);

// File: tb/store_order_buffer_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic against a
// program-order model of stores, loads and fences.
module store_order_buffer_test;
    localparam int DEPTH = 8;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic relaxed = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_req, mem_we, idle;
    logic [DW-1:0] rsp_data, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #2 clk = ~clk;

    store_order_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .relaxed(relaxed),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .idle(idle)
    );

    int tests = 0, fails = 0, cyc = 0;
    logic [AW-1:0] s_addr [4096];
    logic [DW-1:0] s_data [4096];
    bit            s_done [4096];
    int            s_bar  [4096];
    int nst = 0, head = 0, ww_bound = 0;
    logic [DW-1:0] arch [256];
    logic [DW-1:0] mem  [256];
    logic [DW-1:0] exp_q [4096];
    int e_wr = 0, e_rd = 0;
    bit log_we [256];
    int log_addr [256];
    int nlog = 0, nreads = 0, ack_pct = 100;
    bit mem_gate = 1'b1, pend_rd_chk = 1'b0;

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 257 ^ 16'h5a3c);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Judge one memory write against the program-order store record.
    task automatic judge_write(input int a, input int d);
        int k = -1;
        for (int i = head; i < nst; i++) begin
            if (k < 0 && !s_done[i] && int'(s_addr[i]) == a) k = i;
        end
        chk(k >= 0, "R6", "write of unknown store", a, 0);
        if (k < 0) return;
        chk(int'(s_data[k]) == d, "R6", "same-address write order", d, int'(s_data[k]));
        if (!relaxed) chk(k == head, "R5", "in-order write", k, head);
        else chk(head >= s_bar[k], "R9", "write passed a store-store fence", head, s_bar[k]);
        s_done[k] = 1'b1;
        while (head < nst && s_done[head]) head++;
    endtask

    // Memory model and response monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_rd_chk) chk(rsp_valid === 1'b1, "R4", "response cycle after read ack", int'(rsp_valid), 1);
            pend_rd_chk = 1'b0;
            if (rsp_valid) begin
                if (e_rd < e_wr) chk(rsp_data == exp_q[e_rd], "R2", "load data", int'(rsp_data), int'(exp_q[e_rd]));
                else chk(1'b0, "R2", "response without load", 1, 0);
                e_rd++;
            end
            mem_ack = 1'b0;
            if (mem_req && mem_gate && (($urandom % 100) < ack_pct)) begin
                mem_ack = 1'b1;
                if (nlog < 256) begin
                    log_we[nlog] = mem_we;
                    log_addr[nlog] = int'(mem_addr);
                    nlog++;
                end
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    judge_write(int'(mem_addr), int'(mem_wdata));
                end else begin
                    mem_rdata = mem[mem_addr];
                    nreads++;
                    pend_rd_chk = 1'b1;
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R1", "watchdog expired", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Present one request, wait for acceptance and update the model.
    task automatic issue(input int op, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(a); req_wdata = DW'(d);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        case (op)
            0: begin exp_q[e_wr] = arch[a]; e_wr++; end
            1: begin
                s_addr[nst] = AW'(a); s_data[nst] = DW'(d); s_done[nst] = 1'b0;
                s_bar[nst] = ww_bound; nst++; arch[a] = DW'(d);
            end
            5: ww_bound = nst;
            default: ;
        endcase
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        for (int n = 0; n < 2000 && e_rd < e_wr; n++) @(negedge clk);
    endtask

    function automatic bit log_is(input int idx, input bit we, input int a);
        return idx < nlog && log_we[idx] == we && log_addr[idx] == a;
    endfunction

    initial begin
        int r0;
        void'($urandom(32'd7));
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            arch[i] = init_val(i);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(idle === 1'b1, "R1", "idle after reset", int'(idle), 1);
        chk(mem_req === 1'b0 && rsp_valid === 1'b0, "R1", "quiet outputs", int'({mem_req, rsp_valid}), 0);
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // R7: fill the buffer while memory stalls
        mem_gate = 1'b0;
        for (int i = 0; i < DEPTH; i++) issue(1, 8 + i, 16'h100 + i);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 8'h90; #1;
        chk(req_ready === 1'b0, "R7", "store refused when full", int'(req_ready), 0);
        req_valid = 1'b0;

        // R3: forwarded load, no memory access, answer next cycle
        r0 = nreads;
        issue(0, 10, 0);
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R3", "forward response cycle", int'(rsp_valid), 1);
        chk(nreads == r0, "R3", "no memory read on forward", nreads, r0);

        // R4: miss load passes the seven stores not yet started
        nlog = 0;
        issue(0, 8'h40, 0);
        mem_gate = 1'b1;
        wait_rsp();
        chk(log_is(0, 1'b1, 8), "R4", "in-flight write first", log_addr[0], 8);
        chk(log_is(1, 1'b0, 8'h40), "R4", "read ahead of older stores", log_addr[1], 8'h40);

        // R8: store-to-load fence completes with everything drained
        issue(4, 0, 0);
        chk(idle === 1'b1, "R8", "idle after fence", int'(idle), 1);
        chk(head == nst, "R8", "all stores written", head, nst);

        // R6: relaxed drain order, youngest free store first
        @(negedge clk); relaxed = 1'b1;
        mem_gate = 1'b0; nlog = 0;
        issue(1, 8'h20, 1); issue(1, 8'h21, 2); issue(1, 8'h22, 3);
        mem_gate = 1'b1;
        issue(4, 0, 0);
        chk(log_is(0, 1, 8'h20) && log_is(1, 1, 8'h22) && log_is(2, 1, 8'h21), "R6", "relaxed order", log_addr[1], 8'h22);

        // R6: same address keeps program order under relaxed drain
        mem_gate = 1'b0; nlog = 0;
        issue(1, 8'h30, 1); issue(1, 8'h31, 2); issue(1, 8'h30, 3); issue(1, 8'h32, 4);
        mem_gate = 1'b1;
        issue(4, 0, 0);
        chk(log_is(1, 1, 8'h32) && log_is(2, 1, 8'h30) && log_is(3, 1, 8'h31), "R6", "same-address order", log_addr[2], 8'h30);
        issue(0, 8'h30, 0);
        wait_rsp();

        // R9: store-to-store fence holds younger stores
        mem_gate = 1'b0; nlog = 0;
        issue(1, 8'h50, 5); issue(1, 8'h51, 6); issue(5, 0, 0); issue(1, 8'h52, 7); issue(1, 8'h53, 8);
        mem_gate = 1'b1;
        issue(4, 0, 0);
        chk(log_is(1, 1, 8'h51) && log_is(2, 1, 8'h53) && log_is(3, 1, 8'h52), "R9", "fence order", log_addr[2], 8'h53);

        // R10: load fences wait for the outstanding load
        @(negedge clk); relaxed = 1'b0;
        mem_gate = 1'b0;
        issue(0, 8'h60, 0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd2; #1;
        chk(req_ready === 1'b0, "R10", "load-load fence held", int'(req_ready), 0);
        req_op = 3'd3; #1;
        chk(req_ready === 1'b0, "R10", "load-store fence held", int'(req_ready), 0);
        req_valid = 1'b0;
        mem_gate = 1'b1;
        issue(2, 0, 0);
        chk(e_rd == e_wr, "R10", "load answered before fence", e_rd, e_wr);
        issue(3, 0, 0);

        // Random traffic in blocks, each closed by a store-to-load fence.
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            relaxed = 1'($urandom % 2);
            ack_pct = 20 + int'($urandom % 70);
            for (int n = 0; n < 100; n++) begin
                int pick = int'($urandom % 20);
                int a = 8'h70 + int'($urandom % 8);
                int op = (pick < 9) ? 1 : (pick < 16) ? 0 : 2 + int'($urandom % 4);
                issue(op, a, int'($urandom % 65536));
            end
            issue(4, 0, 0);
            chk(idle === 1'b1 && head == nst, "R8", "block drained", head, nst);
        end

        ack_pct = 100;
        wait_rsp();
        chk(e_rd == e_wr, "R2", "all loads answered", e_rd, e_wr);
        summary();
        $finish;
    end
endmodule